// File: doc/BRIEF.md
# Interrupt-Return Frame Pop Controller

This block steps through the stack reads of a long-mode interrupt return. When `start` is pulsed while the block is idle, it captures the return context: the execution mode (full 64-bit or compatibility), the current privilege level, the stack pointer, the current stack selector, and the mode bit of the target code segment. It then issues 8-byte reads through a simple request/valid port. The reads fetch the instruction pointer, the code selector and the flags word. After that the block decides whether the saved stack pointer and stack selector must also be fetched.

The target privilege level is the low two bits of the popped code selector. Once the stack selector has been read, the block checks it. A null selector is accepted only for a 64-bit target running below privilege 3. An accepted null selector raises an indication that the descriptor load for the stack segment must be skipped. Descriptor fetches and limit checks happen elsewhere.

When a return finishes, `done` pulses for one cycle. Alongside it, the block presents either the restored register values or a fault flag. A faulting return leaves the restored-value outputs as they were.

Top module: `iret_pop_ctrl`

## Requirements
- R1: After synchronous reset: `busy`, `done`, `rd_req`, `fault` and `skip_ss_load` are 0, and all restored-value outputs are 0.
- R2: Reads go out in the order instruction pointer, code selector, flags, stack pointer, stack selector. The addresses are the captured stack pointer plus 0, 8, 16, 24 and 32. Each request holds `rd_req` high with a stable `rd_addr` until `rd_valid` is seen.
- R3: In 64-bit mode (`mode64`=1), all five items are read even when the privilege level is unchanged. `new_rsp` and `new_ss` come from the frame.
- R4: In compatibility mode with an unchanged privilege level, only three items are read. `new_rsp` is the start pointer plus 24 and `new_ss` is the captured `cur_ss`.
- R5: In compatibility mode with a privilege level change, all five items are read.
- R6: If the target level (CS bits [1:0]) is numerically lower than `cur_cpl`, the return ends right after the code selector read (two reads). It ends with `fault`=1 and the restored-value outputs unchanged.
- R7: A null stack selector (bits [15:2] all zero, the RPL bits ignored) is accepted when `tgt_is64`=1 and the target level is not 3. It then gives `skip_ss_load`=1, `fault`=0, and `new_ss` equal to the popped value.
- R8: A popped null stack selector with target level 3 or `tgt_is64`=0 gives `fault`=1, `skip_ss_load`=0, and leaves the restored-value outputs unchanged.
- R9: A popped non-null stack selector is loaded into `new_ss` with `skip_ss_load`=0.
- R10: `done` is a one-cycle pulse in the cycle after the last read data is accepted. `busy` is low in that cycle. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a return (taken only when idle) |
| mode64 | input | 1 | 1 = full 64-bit mode, 0 = compatibility mode |
| cur_cpl | input | 2 | Current privilege level |
| cur_rsp | input | 64 | Stack pointer at the return |
| cur_ss | input | 16 | Current stack selector |
| tgt_is64 | input | 1 | Target code segment runs 64-bit code |
| rd_req | output | 1 | Stack read request |
| rd_addr | output | 64 | Stack read address |
| rd_valid | input | 1 | Read data valid; accepts the pending request |
| rd_data | input | 64 | Read data |
| busy | output | 1 | Return in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last return faulted |
| skip_ss_load | output | 1 | Last return accepted a null stack selector |
| new_rip | output | 64 | Restored instruction pointer |
| new_cs | output | 16 | Restored code selector |
| new_rflags | output | 64 | Restored flags |
| new_rsp | output | 64 | Restored stack pointer |
| new_ss | output | 16 | Restored stack selector |

## Verification
A wrong item index or pointer first shows up at the read port. The address of the very next request is off, and so is the number of requests before `done`. Both are seen within one request of the error. A wrong mode or privilege decision shows at the `done` pulse: there is one read too many or too few, a `new_rsp` that does not equal the start pointer plus 24, or a fault or skip flag that disagrees with the popped selectors. The bench compares the read address on every request cycle and every output at each completion. This places any divergence within the return in which it happens.

// File: rtl/iret_pkg.sv
package iret_pkg;
  typedef enum logic {ST_IDLE, ST_READ} seq_st_e;

  localparam int IDX_W     = 3;
  localparam int SLOT_RIP  = 0;
  localparam int SLOT_CS   = 1;
  localparam int SLOT_FLG  = 2;
  localparam int SLOT_RSP  = 3;
  localparam int SLOT_SS   = 4;
  localparam int NSLOT     = 4;

  function automatic logic sel_is_null(input logic [15:0] sel);
    return (sel[15:2] == 14'd0);
  endfunction
endpackage

// File: rtl/iret_frame_regs.sv
module iret_frame_regs
  import iret_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NSLOT-1:0][DATA_W-1:0]  slot_q
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[g] <= '0;
      else if (we && idx == IDX_W'(g)) slot_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/iret_ret_check.sv
module iret_ret_check
  import iret_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             mode64,
  input  logic [1:0]       cur_cpl,
  input  logic             tgt_is64,
  input  logic [SEL_W-1:0] cs_sel,
  input  logic [SEL_W-1:0] ss_sel,
  output logic             need_ss,
  output logic             priv_fault,
  output logic             ss_null,
  output logic             null_fault
);
  logic [1:0] tgt_cpl;
  always_comb begin
    tgt_cpl    = cs_sel[1:0];
    priv_fault = (tgt_cpl < cur_cpl);
    need_ss    = mode64 || (tgt_cpl != cur_cpl);
    ss_null    = sel_is_null(16'(ss_sel));
    null_fault = ss_null && (!tgt_is64 || tgt_cpl == 2'd3);
  end
endmodule

// File: rtl/iret_seq.sv
module iret_seq
  import iret_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 16,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode64,
  input  logic [1:0]        cur_cpl,
  input  logic [ADDR_W-1:0] cur_rsp,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic              tgt_is64,
  input  logic              rd_valid,
  input  logic              need_ss,
  input  logic              priv_fault,
  input  logic              null_fault,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  idx,
  output logic              take,
  output logic              fin,
  output logic              fin_fault,
  output logic              ctx_mode64,
  output logic [1:0]        ctx_cpl,
  output logic [SEL_W-1:0]  ctx_ss,
  output logic              ctx_tgt64
);
  seq_st_e state;

  assign busy    = (state == ST_READ);
  assign rd_req  = busy;
  assign take    = busy && rd_valid;

  always_comb begin
    fin       = 1'b0;
    fin_fault = 1'b0;
    if (take) begin
      unique case (idx)
        IDX_W'(SLOT_CS):  begin fin = priv_fault; fin_fault = priv_fault; end
        IDX_W'(SLOT_FLG): fin = !need_ss;
        IDX_W'(SLOT_SS):  begin fin = 1'b1; fin_fault = null_fault; end
        default:          fin = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      rd_addr    <= '0;
      ctx_mode64 <= 1'b0;
      ctx_cpl    <= '0;
      ctx_ss     <= '0;
      ctx_tgt64  <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state      <= ST_READ;
        idx        <= '0;
        rd_addr    <= cur_rsp;
        ctx_mode64 <= mode64;
        ctx_cpl    <= cur_cpl;
        ctx_ss     <= cur_ss;
        ctx_tgt64  <= tgt_is64;
      end
    end else if (take) begin
      rd_addr <= rd_addr + ADDR_W'(STEP);
      idx     <= idx + 1'b1;
      if (fin) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/iret_pop_ctrl.sv
module iret_pop_ctrl
  import iret_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode64,
  input  logic [1:0]        cur_cpl,
  input  logic [ADDR_W-1:0] cur_rsp,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic              tgt_is64,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              skip_ss_load,
  output logic [DATA_W-1:0] new_rip,
  output logic [SEL_W-1:0]  new_cs,
  output logic [DATA_W-1:0] new_rflags,
  output logic [ADDR_W-1:0] new_rsp,
  output logic [SEL_W-1:0]  new_ss
);
  localparam int STEP = DATA_W / 8;

  logic [IDX_W-1:0]             idx;
  logic                         take, fin, fin_fault;
  logic                         ctx_mode64, ctx_tgt64;
  logic [1:0]                   ctx_cpl;
  logic [SEL_W-1:0]             ctx_ss;
  logic                         need_ss, priv_fault, ss_null, null_fault;
  logic [NSLOT-1:0][DATA_W-1:0] slot_q;
  logic [SEL_W-1:0]             cs_sel;

  assign cs_sel = (idx == IDX_W'(SLOT_CS)) ? rd_data[SEL_W-1:0]
                                           : slot_q[SLOT_CS][SEL_W-1:0];

  iret_seq #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .STEP(STEP)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode64(mode64), .cur_cpl(cur_cpl),
    .cur_rsp(cur_rsp), .cur_ss(cur_ss), .tgt_is64(tgt_is64),
    .rd_valid(rd_valid), .need_ss(need_ss), .priv_fault(priv_fault),
    .null_fault(null_fault), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .idx(idx), .take(take), .fin(fin), .fin_fault(fin_fault),
    .ctx_mode64(ctx_mode64), .ctx_cpl(ctx_cpl), .ctx_ss(ctx_ss),
    .ctx_tgt64(ctx_tgt64)
  );

  iret_ret_check #(.SEL_W(SEL_W)) u_chk_logic (
    .mode64(ctx_mode64), .cur_cpl(ctx_cpl), .tgt_is64(ctx_tgt64),
    .cs_sel(cs_sel), .ss_sel(rd_data[SEL_W-1:0]), .need_ss(need_ss),
    .priv_fault(priv_fault), .ss_null(ss_null), .null_fault(null_fault)
  );

  iret_frame_regs #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .we(take), .idx(idx), .wdata(rd_data),
    .slot_q(slot_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      fault        <= 1'b0;
      skip_ss_load <= 1'b0;
      new_rip      <= '0;
      new_cs       <= '0;
      new_rflags   <= '0;
      new_rsp      <= '0;
      new_ss       <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        fault        <= fin_fault;
        skip_ss_load <= !fin_fault && need_ss && ss_null;
        if (!fin_fault) begin
          new_rip    <= slot_q[SLOT_RIP];
          new_cs     <= slot_q[SLOT_CS][SEL_W-1:0];
          if (need_ss) begin
            new_rflags <= slot_q[SLOT_FLG];
            new_rsp    <= slot_q[SLOT_RSP][ADDR_W-1:0];
            new_ss     <= rd_data[SEL_W-1:0];
          end else begin
            new_rflags <= rd_data;
            new_rsp    <= rd_addr + ADDR_W'(STEP);
            new_ss     <= ctx_ss;
          end
        end
      end
    end
  end
endmodule

// File: rtl/iret_pop_ctrl_chk.sv
module iret_pop_ctrl_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SEL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              skip_ss_load,
  input logic [SEL_W-1:0]  new_ss
);
  localparam int STEP = DATA_W / 8;

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(STEP)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_skip_null: assert property (@(posedge clk) disable iff (rst)
    (done && skip_ss_load) |-> (!fault && new_ss[SEL_W-1:2] == '0));

  a_r8_fault_no_skip: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> !skip_ss_load);
endmodule

bind iret_pop_ctrl iret_pop_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_prop (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .busy(busy), .done(done), .fault(fault), .skip_ss_load(skip_ss_load),
  .new_ss(new_ss)
);

// File: tb/iret_pop_ctrl_tb.sv
module iret_pop_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, start, mode64, tgt_is64, rd_valid;
  logic [1:0]  cur_cpl;
  logic [63:0] cur_rsp, rd_data;
  logic [15:0] cur_ss;
  logic        rd_req, busy, done, fault, skip_ss_load;
  logic [63:0] rd_addr, new_rip, new_rflags, new_rsp;
  logic [15:0] new_cs, new_ss;

  int checks = 0;
  int failures = 0;

  logic [63:0] e_rip, e_fl, e_rsp;
  logic [15:0] e_cs, e_ss;
  logic [63:0] mem [logic [63:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  iret_pop_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .mode64(mode64), .cur_cpl(cur_cpl),
    .cur_rsp(cur_rsp), .cur_ss(cur_ss), .tgt_is64(tgt_is64),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .fault(fault), .skip_ss_load(skip_ss_load),
    .new_rip(new_rip), .new_cs(new_cs), .new_rflags(new_rflags),
    .new_rsp(new_rsp), .new_ss(new_ss)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_ret(input string req, input logic m64, input logic [1:0] cpl,
                         input logic [63:0] rsp, input logic [15:0] css,
                         input logic t64, input logic [63:0] f_rip,
                         input logic [15:0] f_cs, input logic [63:0] f_fl,
                         input logic [63:0] f_rsp, input logic [15:0] f_ss,
                         input int lat, input bit poke);
    logic [1:0] tcpl;
    bit privf, need, nul, nullf, flt;
    int nreads, n, w, cyc;
    tcpl   = f_cs[1:0];
    privf  = (tcpl < cpl);
    need   = m64 || (tcpl != cpl);
    nul    = (f_ss[15:2] == 14'd0);
    nullf  = need && nul && (!t64 || tcpl == 2'd3);
    flt    = privf || nullf;
    nreads = privf ? 2 : (need ? 5 : 3);
    mem[rsp] = f_rip; mem[rsp+8] = {48'h0, f_cs}; mem[rsp+16] = f_fl;
    mem[rsp+24] = f_rsp; mem[rsp+32] = {48'hABCD_0000_0000, f_ss};
    @(negedge clk);
    mode64 = m64; cur_cpl = cpl; cur_rsp = rsp; cur_ss = css; tgt_is64 = t64;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; w = 0; cyc = 0;
    while (!done && cyc < 200) begin
      if (poke && cyc == 1) begin
        start = 1'b1; mode64 = ~m64; cur_rsp = rsp + 64'h1000; cur_cpl = 2'd0;
      end else begin
        start = 1'b0;
      end
      if (rd_req) begin
        chk({req, " R2 addr"}, rd_addr, rsp + 64'(8*n));
        if (w >= lat) begin
          rd_valid = 1'b1; rd_data = mem.exists(rd_addr) ? mem[rd_addr] : 64'hDEAD;
          n++; w = 0;
        end else begin
          rd_valid = 1'b0; w++;
        end
      end else begin
        rd_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; rd_valid = 1'b0;
    chk({req, " R10 done seen"}, 64'(done), 64'd1);
    chk({req, " R10 busy low at done"}, 64'(busy), 64'd0);
    chk({req, " read count"}, 64'(n), 64'(nreads));
    chk({req, " fault"}, 64'(fault), 64'(flt));
    chk({req, " skip_ss_load"}, 64'(skip_ss_load), 64'(!flt && need && nul));
    if (!flt) begin
      e_rip = f_rip; e_cs = f_cs; e_fl = f_fl;
      e_rsp = need ? f_rsp : rsp + 64'd24;
      e_ss  = need ? f_ss : css;
    end
    chk({req, " new_rip"}, new_rip, e_rip);
    chk({req, " new_cs"}, 64'(new_cs), 64'(e_cs));
    chk({req, " new_rflags"}, new_rflags, e_fl);
    chk({req, " new_rsp"}, new_rsp, e_rsp);
    chk({req, " new_ss"}, 64'(new_ss), 64'(e_ss));
    @(negedge clk);
    chk({req, " R10 done pulse one cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; mode64 = 1'b0; cur_cpl = '0; cur_rsp = '0;
    cur_ss = '0; tgt_is64 = 1'b0; rd_valid = 1'b0; rd_data = '0;
    e_rip = '0; e_cs = '0; e_fl = '0; e_rsp = '0; e_ss = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0); chk("R1 done", 64'(done), 0);
    chk("R1 rd_req", 64'(rd_req), 0); chk("R1 fault", 64'(fault), 0);
    chk("R1 skip", 64'(skip_ss_load), 0); chk("R1 new_rsp", new_rsp, 0);
    chk("R1 new_ss", 64'(new_ss), 0); chk("R1 new_rip", new_rip, 0);
    rst = 1'b0;
    // R3 R9: 64-bit mode, same level, non-null SS
    run_ret("R3", 1, 0, 64'h1000, 16'h0010, 1, 64'h1111, 16'h0008, 64'h202, 64'h8000, 16'h0018, 0, 0);
    // R4: compatibility, same level
    run_ret("R4", 0, 3, 64'h2000, 16'h002B, 0, 64'h2222, 16'h0023, 64'h246, 64'h9999, 16'h0033, 1, 0);
    // R5 R9: compatibility, level change to outer
    run_ret("R5", 0, 0, 64'h3000, 16'h0010, 0, 64'h3333, 16'h0023, 64'h2, 64'h7000, 16'h002B, 2, 0);
    // R7: null SS accepted, 64-bit target, level 0
    run_ret("R7", 1, 0, 64'h4000, 16'h0010, 1, 64'h4444, 16'h0008, 64'h46, 64'h6000, 16'h0000, 0, 0);
    // R7: null with RPL bits set, target level 2
    run_ret("R7 rpl", 1, 1, 64'h4100, 16'h0011, 1, 64'h4545, 16'h000A, 64'h47, 64'h6100, 16'h0002, 1, 0);
    // R8: null SS to level 3
    run_ret("R8 cpl3", 1, 0, 64'h5000, 16'h0010, 1, 64'h5555, 16'h0033, 64'h1, 64'h5100, 16'h0003, 0, 0);
    // R8: null SS to non-64-bit target
    run_ret("R8 t32", 0, 0, 64'h5800, 16'h0010, 0, 64'h5858, 16'h0021, 64'h1, 64'h5900, 16'h0000, 1, 0);
    // R6: return to more privileged level
    run_ret("R6", 1, 3, 64'h6000, 16'h002B, 1, 64'h6666, 16'h0008, 64'h1, 64'h6100, 16'h0010, 1, 0);
    // R10: start ignored while busy
    run_ret("R10 poke", 0, 2, 64'h7000, 16'h0022, 0, 64'h7777, 16'h001A, 64'h3, 64'h7100, 16'h0012, 2, 1);
    // R4 again after a fault, zero latency
    run_ret("R4 b", 0, 1, 64'h8000, 16'h0019, 1, 64'h8888, 16'h0011, 64'h5, 64'h8100, 16'h0000, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule